// File: doc/BRIEF.md
# Pipelined Row-Select Decoder

This block turns an N-bit binary row address into 2^N select lines, one per row, for driving word lines of a register file or a memory array. Each select line is the AND of the N address literals plus an internal enable literal. That AND is built as a tree of gates whose fan-in never exceeds a parameter. Unused gate inputs are held at logic 1.

A parameter chooses the output polarity: active-high (one line high, the rest low) or active-low (one line low, the rest high, as from NAND gates). Another parameter places a register after every P tree levels, and P = 0 gives no tree registers. Every select line passes through the same number of registers, so all lines change in the same cycle. An input register, an output register and an enable pin are each switched in or out by parameter.

A synchronous active-high reset puts every register into the inactive state. The decoder then shows the idle pattern until the first address has reached the outputs.

Top module: `rowsel_decoder`

## Requirements
- R1: With active-high polarity (ACT_LOW = 0), bit k of `lines` is 1 exactly when the address that produced it equalled k, and every other bit is 0. For example, address 2 gives only bit 2 high.
- R2: With active-low polarity (ACT_LOW = 1), bit k of `lines` is 0 for the selected address k, and all other bits are 1.
- R3: In every cycle after reset, at most one line is in its active level.
- R4: With HAS_EN = 1, an address presented while `en` is 0 produces the idle pattern: all 0 when active-high, all 1 when active-low.
- R5: With HAS_EN = 0, the `en` pin has no effect on `lines`.
- R6: Latency in cycles is IN_REG + OUT_REG + S. S = 0 when PIPE_LVL = 0. Otherwise S = floor((D-1)/PIPE_LVL), where D is the number of rounds of ceil(n/FANIN) that reduce n = ADDR_W+1 leaves to one.
- R7: Decoding is correct for any FANIN of 2 or more, including fan-ins that leave gate inputs unused.
- R8: A synchronous reset makes `lines` idle in the cycle after the reset edge. The lines stay idle until the first address presented after reset emerges.
- R9: A new address can be accepted every cycle, and consecutive addresses emerge on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Decode enable, active high (ignored when HAS_EN = 0) |
| addr | input | ADDR_W | Binary row address |
| lines | output | 2**ADDR_W | Row select lines |

## Verification
The difficult case is when a change in enable and a change in address occur in the same cycle. If the enable literal were not delayed through exactly as many registers as the address literals, a stale row would flash active, or a fresh row would be swallowed. The bench changes `en` and `addr` on the same edge repeatedly, both in directed sequences and in random ones. It also asserts reset while addresses are in flight. A behavioural shift model compares each cycle's lines against the expected one-hot or one-cold word. A second instance with active-low polarity, fan-in 3, no input register and no enable pin is checked in parallel.

// File: rtl/rowdec_pkg.sv
package rowdec_pkg;

   // gate levels needed to reduce `leaves` signals to one with fan-in `fanin`
   function automatic int tree_depth(input int leaves, input int fanin);
      int n;
      int d;
      n = leaves;
      d = 0;
      for (int i = 0; i < 64; i++) begin
         if (n > 1) begin
            n = (n + fanin - 1) / fanin;
            d++;
         end
      end
      return d;
   endfunction

   // number of gate outputs present after `lvl` levels
   function automatic int nodes_at(input int leaves, input int fanin, input int lvl);
      int n;
      n = leaves;
      for (int i = 0; i < lvl; i++) n = (n + fanin - 1) / fanin;
      return n;
   endfunction

   // register cuts inside a tree of the given depth
   function automatic int cut_count(input int depth, input int pipe_lvl);
      if (pipe_lvl == 0 || depth < 1) return 0;
      return (depth - 1) / pipe_lvl;
   endfunction

endpackage

// File: rtl/rowdec_and_tree.sv
module rowdec_and_tree #(
   parameter int LEAVES   = 5,
   parameter int FANIN    = 2,
   parameter int PIPE_LVL = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [LEAVES-1:0] leaf,
   output logic              hit
);
   import rowdec_pkg::*;

   localparam int DEPTH  = tree_depth(LEAVES, FANIN);
   localparam int STAGES = cut_count(DEPTH, PIPE_LVL);

   generate
      if (LEAVES < 2) begin : g_bad_leaves
         $error("rowdec_and_tree: LEAVES must be at least 2");
      end
      if (FANIN < 2) begin : g_bad_fanin
         $error("rowdec_and_tree: FANIN must be at least 2");
      end
   endgenerate

   logic [LEAVES-1:0] lvl [0:DEPTH];
   assign lvl[0] = leaf;

   generate
      for (genvar k = 1; k <= DEPTH; k++) begin : g_lvl
         localparam int NPREV = nodes_at(LEAVES, FANIN, k - 1);
         localparam int NCUR  = nodes_at(LEAVES, FANIN, k);
         logic [LEAVES-1:0] nxt;

         always_comb begin
            nxt = '0;
            for (int j = 0; j < NCUR; j++) begin
               nxt[j] = 1'b1;                 // spare gate inputs sit at 1
               for (int i = 0; i < FANIN; i++) begin
                  if (j * FANIN + i < NPREV) nxt[j] = nxt[j] & lvl[k-1][j*FANIN+i];
               end
            end
         end

         if (PIPE_LVL != 0 && (k % PIPE_LVL) == 0 && k < DEPTH) begin : g_cut
            always_ff @(posedge clk) begin
               if (rst) lvl[k] <= '0;
               else     lvl[k] <= nxt;
            end
         end else begin : g_wire
            assign lvl[k] = nxt;
         end
      end
   endgenerate

   assign hit = lvl[DEPTH][0];

   // checker: a flat AND of the leaves, delayed by the same number of cuts
   logic ref_hit;
   generate
      if (STAGES > 0) begin : g_ref_dly
         logic [STAGES-1:0] dly;
         always_ff @(posedge clk) begin
            if (rst) dly <= '0;
            else begin
               dly[0] <= &leaf;
               for (int s = 1; s < STAGES; s++) dly[s] <= dly[s-1];
            end
         end
         assign ref_hit = dly[STAGES-1];
      end else begin : g_ref_flat
         assign ref_hit = &leaf;
      end
   endgenerate

   // R7
   tree_match_chk: assert property (@(posedge clk) disable iff (rst) hit == ref_hit);

endmodule

// File: rtl/rowsel_decoder.sv
module rowsel_decoder #(
   parameter int ADDR_W   = 4,
   parameter int FANIN    = 2,
   parameter int PIPE_LVL = 1,
   parameter bit IN_REG   = 1'b1,
   parameter bit OUT_REG  = 1'b1,
   parameter bit HAS_EN   = 1'b1,
   parameter bit ACT_LOW  = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 en,
   input  logic [ADDR_W-1:0]    addr,
   output logic [2**ADDR_W-1:0] lines
);
   import rowdec_pkg::*;

   localparam int NLINES  = 2 ** ADDR_W;
   localparam int LEAVES  = ADDR_W + 1;
   localparam int DEPTH   = tree_depth(LEAVES, FANIN);
   localparam int STAGES  = cut_count(DEPTH, PIPE_LVL);
   localparam int LATENCY = int'(IN_REG) + int'(OUT_REG) + STAGES;
   localparam logic [NLINES-1:0] IDLE = ACT_LOW ? '1 : '0;

   generate
      if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_width
         $error("rowsel_decoder: ADDR_W must lie in 1..10");
      end
      if (FANIN < 2) begin : g_bad_fanin
         $error("rowsel_decoder: FANIN must be at least 2");
      end
      if (PIPE_LVL < 0) begin : g_bad_pipe
         $error("rowsel_decoder: PIPE_LVL must not be negative");
      end
   endgenerate

   // enable literal: constant 1 when the pin is not in use
   logic en_lit;
   generate
      if (HAS_EN) begin : g_en
         assign en_lit = en;
      end else begin : g_no_en
         logic unused_en;
         assign unused_en = en;
         assign en_lit    = 1'b1;
      end
   endgenerate

   // optional input stage; reset clears the enable literal so rows stay idle
   logic [ADDR_W-1:0] addr_s;
   logic              en_s;
   generate
      if (IN_REG) begin : g_in_reg
         always_ff @(posedge clk) begin
            if (rst) begin
               addr_s <= '0;
               en_s   <= 1'b0;
            end else begin
               addr_s <= addr;
               en_s   <= en_lit;
            end
         end
      end else begin : g_in_wire
         assign addr_s = addr;
         assign en_s   = en_lit;
      end
   endgenerate

   // one bounded fan-in AND tree per row
   logic [NLINES-1:0] hit;
   generate
      for (genvar r = 0; r < NLINES; r++) begin : g_row
         localparam logic [ADDR_W-1:0] ROW = ADDR_W'(r);
         logic [LEAVES-1:0] leaf;
         assign leaf = {en_s, addr_s ^ ~ROW};
         rowdec_and_tree #(
            .LEAVES  (LEAVES),
            .FANIN   (FANIN),
            .PIPE_LVL(PIPE_LVL)
         ) tree_i (
            .clk (clk),
            .rst (rst),
            .leaf(leaf),
            .hit (hit[r])
         );
      end
   endgenerate

   logic [NLINES-1:0] pol;
   generate
      if (ACT_LOW) begin : g_low
         assign pol = ~hit;
      end else begin : g_high
         assign pol = hit;
      end
   endgenerate

   generate
      if (OUT_REG) begin : g_out_reg
         always_ff @(posedge clk) begin
            if (rst) lines <= IDLE;
            else     lines <= pol;
         end
      end else begin : g_out_wire
         assign lines = pol;
      end
   endgenerate

   // ---------------- checks ----------------
   // R3
   one_active_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(ACT_LOW ? ~lines : lines));

   logic rst_d;
   always_ff @(posedge clk) begin
      rst_d <= rst;
      if (OUT_REG && rst_d && !rst) begin
         // R8
         reset_idle_chk: assert (lines == IDLE);
      end
   end

   // enable literal delayed by the full latency, as the checker's own view
   logic en_late;
   generate
      if (LATENCY > 0) begin : g_en_dly
         logic [LATENCY-1:0] en_pipe;
         always_ff @(posedge clk) begin
            if (rst) en_pipe <= '0;
            else begin
               en_pipe[0] <= en_lit;
               for (int s = 1; s < LATENCY; s++) en_pipe[s] <= en_pipe[s-1];
            end
         end
         assign en_late = en_pipe[LATENCY-1];
      end else begin : g_en_now
         assign en_late = en_lit;
      end
   endgenerate

   // R4
   disabled_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !en_late |-> lines == IDLE);

endmodule

// File: tb/rowsel_decoder_tb_top.sv
module rowsel_decoder_tb_top;

   // instance A: active-high, fan-in 2, cut every level, in/out regs, enable
   localparam int AW_A = 4, FI_A = 2, PL_A = 1, IR_A = 1, OR_A = 1;
   // instance B: active-low, fan-in 3, cut every level, no input reg, no enable
   localparam int AW_B = 3, FI_B = 3, PL_B = 1, IR_B = 0, OR_B = 1;

   function automatic int bench_depth(input int n0, input int f);
      int n, d;
      n = n0;
      d = 0;
      for (int i = 0; i < 40; i++) if (n > 1) begin n = (n + f - 1) / f; d++; end
      return d;
   endfunction

   function automatic int bench_lat(input int aw, input int f, input int p, input int ir, input int orr);
      int d;
      d = bench_depth(aw + 1, f);
      return ir + orr + ((p == 0) ? 0 : (d - 1) / p);
   endfunction

   localparam int LAT_A = bench_lat(AW_A, FI_A, PL_A, IR_A, OR_A);
   localparam int LAT_B = bench_lat(AW_B, FI_B, PL_B, IR_B, OR_B);

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic en  = 1'b0;
   logic [3:0] sel = '0;
   logic [15:0] lines_a;
   logic [7:0]  lines_b;

   always #4 clk = ~clk;   // 8 ns period

   rowsel_decoder #(.ADDR_W(AW_A), .FANIN(FI_A), .PIPE_LVL(PL_A), .IN_REG(1'b1),
                    .OUT_REG(1'b1), .HAS_EN(1'b1), .ACT_LOW(1'b0)) dut_i (
      .clk(clk), .rst(rst), .en(en), .addr(sel), .lines(lines_a));

   rowsel_decoder #(.ADDR_W(AW_B), .FANIN(FI_B), .PIPE_LVL(PL_B), .IN_REG(1'b0),
                    .OUT_REG(1'b1), .HAS_EN(1'b0), .ACT_LOW(1'b1)) dut_b_i (
      .clk(clk), .rst(rst), .en(en), .addr(sel[2:0]), .lines(lines_b));

   int errors = 0;
   int checks = 0;
   bit checking = 1'b0;
   bit done = 1'b0;

   // behavioural reference: shift lines of expected words and their tags
   logic [15:0] exp_a [0:LAT_A-1];
   string       tag_a [0:LAT_A-1];
   logic [7:0]  exp_b [0:LAT_B-1];
   string       tag_b [0:LAT_B-1];
   logic [3:0]  last_sel = '0;

   always @(posedge clk) begin
      for (int i = LAT_A - 1; i > 0; i--) begin
         exp_a[i] <= rst ? 16'h0 : exp_a[i-1];
         tag_a[i] <= rst ? "R8" : tag_a[i-1];
      end
      for (int i = LAT_B - 1; i > 0; i--) begin
         exp_b[i] <= rst ? 8'hFF : exp_b[i-1];
         tag_b[i] <= rst ? "R8" : tag_b[i-1];
      end
      if (rst) begin
         exp_a[0] <= 16'h0;  tag_a[0] <= "R8";
         exp_b[0] <= 8'hFF;  tag_b[0] <= "R8";
      end else begin
         exp_a[0] <= en ? (16'h1 << sel) : 16'h0;
         tag_a[0] <= !en ? "R4" : ((sel != last_sel) ? "R1 R6 R9" : "R1 R6");
         exp_b[0] <= ~(8'h1 << sel[2:0]);
         tag_b[0] <= !en ? "R5 R2 R7" : "R2 R7";
      end
      last_sel <= sel;
   end

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (checking && !done) begin
         check(tag_a[LAT_A-1], lines_a, exp_a[LAT_A-1]);
         check(tag_b[LAT_B-1], {8'h0, lines_b}, {8'h0, exp_b[LAT_B-1]});
         // R3: never more than one active line
         check("R3", 16'($countones(lines_a) <= 1), 16'h1);
         check("R3", 16'($countones(~lines_b) <= 1), 16'h1);
      end
   end

   task automatic summary();
      $display("  Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      rst = 1'b1; en = 1'b0; sel = 4'h0;
      @(negedge clk);
      checking = 1'b1;                      // R8 reset state checked from here
      repeat (2) @(negedge clk);
      rst = 1'b0; en = 1'b1;
      // R9: back-to-back ascending addresses
      for (int v = 0; v < 16; v++) begin sel = 4'(v); @(negedge clk); end
      // R4/R5: enable low while the address keeps moving
      en = 1'b0;
      for (int v = 0; v < 5; v++) begin sel = 4'(3 * v + 1); @(negedge clk); end
      // enable and address change on the same edge, toggling
      for (int v = 0; v < 12; v++) begin
         en = v[0];
         sel = 4'(15 - v);
         @(negedge clk);
      end
      en = 1'b1;
      for (int v = 15; v >= 0; v--) begin sel = 4'(v); @(negedge clk); end
      // random traffic
      for (int v = 0; v < 400; v++) begin
         sel = 4'($urandom);
         en  = ($urandom % 4) != 0;
         @(negedge clk);
      end
      // R8: reset while addresses are in flight
      sel = 4'd5; en = 1'b1; rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      sel = 4'd9;
      @(negedge clk);
      for (int v = 0; v < 150; v++) begin
         sel = 4'($urandom);
         en  = ($urandom % 3) != 0;
         @(negedge clk);
      end
      en = 1'b1;
      repeat (LAT_A + 2) @(negedge clk);
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         summary();
         $finish;
      end
   end

endmodule